// File: doc/BRIEF.md
# One-Shot Interval Timer with Sticky Expiry Flag

This block is a programmable single-shot interval timer for a small 4-bit controller core. A start strobe carries an 8-bit argument. At the edge that accepts the strobe, the block clears its expiry flag and loads a 6-bit length field. It then counts whole interval units, each built from a fixed number of input clocks. When the last unit ends, the block raises a sticky expiry flag and stops.

The core checks the flag with a test strobe. The flag level, gated by that strobe, drives a conditional-skip decision, and the test itself never disturbs the flag. Only a new start, or reset, brings the flag back to zero.

The upper two bits of the argument should hold the binary tag `10`. Any other tag raises a single-cycle warning, and the timer starts anyway.

Top module: `ivt_timer`

## Requirements
- R1: At the clock edge that accepts `start_i`, `flag_o` goes to 0 and `running_o` goes to 1. This holds even if the flag was set before.
- R2: With length field `L = start_arg_i[5:0]`, `flag_o` rises at the (L+1)*252-th clock edge after the start edge, counted from 1. One unit is 63 machine cycles of 4 clocks, so the shortest interval is 252 clocks and the longest is 16128 clocks.
- R3: The bits `start_arg_i[7:6]` have no effect on the interval length.
- R4: After expiry the timer stays stopped, with `running_o` low, and `flag_o` stays at 1 until the next start or reset. There is no automatic reload.
- R5: `skip_o` equals `test_i AND flag_o`. Pulsing `test_i` does not change `flag_o`.
- R6: While `rst_i` is high, `flag_o`, `running_o` and `warn_o` are 0 on the following edge. After reset, no expiry can happen until a start is accepted.
- R7: `warn_o` is high for exactly the one cycle after a start edge whose `start_arg_i[7:6]` is not `2'b10`; in every other cycle it is low. The timer still starts.
- R8: A start accepted while the timer is running restarts the count from the new length, with the clock prescaler cleared. The new interval is timed as in R2 from the new start edge.
- R9: `running_o` is high from the cycle after a start until the edge at which `flag_o` rises, and it falls on that same edge. `flag_o` and `running_o` are never high together.
- R10: If a start is accepted on the same edge at which the running interval would expire, the start wins: `flag_o` stays 0 and the new interval begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle per command |
| start_arg_i | input | 8 | Start argument: tag in [7:6], length field in [5:0] |
| test_i | input | 1 | Test strobe from the core |
| flag_o | output | 1 | Sticky expiry flag |
| running_o | output | 1 | High while an interval is counting |
| warn_o | output | 1 | One-cycle pulse for an unexpected argument tag |
| skip_o | output | 1 | Skip decision: test strobe gated by the flag |

## Verification
The bound checker verifies, on every cycle, the relations that hold step by step:
- a start clears the flag and raises `running_o`;
- the flag holds once set and never rises while idle;
- the flag and `running_o` are mutually exclusive;
- a warning pulse is always preceded by a start and lasts one cycle;
- reset leaves all outputs low.

The exact interval length cannot be expressed as a short property. Only the bench scenarios can show it, by counting clock edges between the start and the flag edge. The same applies to:
- interval lengths at the minimum, at a middle value and at the maximum;
- the argument tag having no effect on length;
- a restart clearing the prescaler;
- a start winning over a coinciding expiry.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Default geometry of the timer
    localparam int unsigned IVT_LEN_W        = 6;
    localparam int unsigned IVT_CLK_PER_CYC  = 4;
    localparam int unsigned IVT_CYC_PER_UNIT = 63;

    // Tag expected in the two upper argument bits
    localparam logic [1:0] IVT_TAG_OK = 2'b10;

    typedef enum logic {
        IVT_IDLE = 1'b0,
        IVT_RUN  = 1'b1
    } ivt_state_e;

    function automatic logic ivt_tag_bad(input logic [1:0] tag);
        return tag != IVT_TAG_OK;
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int unsigned PERIOD = 252,
    localparam int unsigned PW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic en_i,
    output logic tick_o
);
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
        end
    end
endmodule

// File: rtl/ivt_unit_counter.sv
module ivt_unit_counter #(
    parameter int unsigned LEN_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             tick_i,
    output logic             expire_o
);
    logic [LEN_W-1:0] left_q;

    // Last unit ends when a tick arrives with nothing left to count
    assign expire_o = tick_i && (left_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= len_i;
        end else if (tick_i && left_q != '0) begin
            left_q <= left_q - LEN_W'(1);
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned LEN_W        = IVT_LEN_W,
    parameter int unsigned CLK_PER_CYC  = IVT_CLK_PER_CYC,
    parameter int unsigned CYC_PER_UNIT = IVT_CYC_PER_UNIT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [LEN_W+1:0] start_arg_i,
    input  logic             test_i,
    output logic             flag_o,
    output logic             running_o,
    output logic             warn_o,
    output logic             skip_o
);
    localparam int unsigned CLK_PER_UNIT = CLK_PER_CYC * CYC_PER_UNIT;

    ivt_state_e       state_q;
    logic             flag_q;
    logic             warn_q;
    logic             tick;
    logic             expire;
    logic [LEN_W-1:0] len_field;
    logic [1:0]       tag_field;

    assign len_field = start_arg_i[LEN_W-1:0];
    assign tag_field = start_arg_i[LEN_W+1:LEN_W];

    ivt_prescaler #(.PERIOD(CLK_PER_UNIT)) u_pre (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (start_i),
        .en_i    (state_q == IVT_RUN),
        .tick_o  (tick)
    );

    ivt_unit_counter #(.LEN_W(LEN_W)) u_units (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (start_i),
        .len_i    (len_field),
        .tick_i   (tick),
        .expire_o (expire)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= IVT_IDLE;
            flag_q  <= 1'b0;
            warn_q  <= 1'b0;
        end else begin
            warn_q <= start_i && ivt_tag_bad(tag_field);
            if (start_i) begin
                // A start takes priority over a coinciding expiry
                state_q <= IVT_RUN;
                flag_q  <= 1'b0;
            end else if (expire) begin
                state_q <= IVT_IDLE;
                flag_q  <= 1'b1;
            end
        end
    end

    assign flag_o    = flag_q;
    assign running_o = (state_q == IVT_RUN);
    assign warn_o    = warn_q;
    assign skip_o    = test_i && flag_q;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic test_i,
    input logic flag_o,
    input logic running_o,
    input logic warn_o,
    input logic skip_o
);
    p_start_clears_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (!flag_o && running_o));

    p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_o && !start_i) |=> flag_o);

    p_test_keeps_flag_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_i && !start_i && !running_o) |=> (flag_o == $past(flag_o)));

    p_skip_needs_flag_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        skip_o |-> (flag_o && test_i));

    p_reset_clears_r6: assert property (@(posedge clk_i)
        rst_i |=> (!flag_o && !running_o && !warn_o));

    p_idle_no_expiry_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!running_o && !flag_o && !start_i) |=> !flag_o);

    p_warn_after_start_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        warn_o |-> $past(start_i));

    p_warn_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (warn_o && !start_i) |=> !warn_o);

    p_flag_rise_stops_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(flag_o) |-> !running_o);

    p_exclusive_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(flag_o && running_o));
endmodule

bind ivt_timer ivt_timer_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .test_i    (test_i),
    .flag_o    (flag_o),
    .running_o (running_o),
    .warn_o    (warn_o),
    .skip_o    (skip_o)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT_CLK   = 252;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] start_arg_i = '0;
    logic       test_i = 1'b0;
    logic       flag_o, running_o, warn_o, skip_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_timer u0 (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .start_i     (start_i),
        .start_arg_i (start_arg_i),
        .test_i      (test_i),
        .flag_o      (flag_o),
        .running_o   (running_o),
        .warn_o      (warn_o),
        .skip_o      (skip_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge right after the start edge
    task automatic start_cmd(input logic [7:0] a);
        start_i     = 1'b1;
        start_arg_i = a;
        @(negedge clk);
        start_i     = 1'b0;
        start_arg_i = '0;
    endtask

    // Full interval from a start: exact expiry edge, running, warning
    task automatic run_interval(input string req, input logic [7:0] a, input int warn_exp);
        int len;
        len = (int'(a[5:0]) + 1) * UNIT_CLK;
        start_cmd(a);
        check({req, " R1 flag cleared"}, flag_o, 0);
        check({req, " R9 running"}, running_o, 1);
        check({req, " R7 warn"}, warn_o, warn_exp);
        wait_n(1);
        check({req, " R7 warn one cycle"}, warn_o, 0);
        wait_n(len - 2);
        check({req, " R2 flag low before end"}, flag_o, 0);
        check({req, " R9 running before end"}, running_o, 1);
        wait_n(1);
        check({req, " R2 flag at end"}, flag_o, 1);
        check({req, " R9 running falls"}, running_o, 0);
    endtask

    task automatic t_reset;
        check("R6 reset flag", flag_o, 0);
        check("R6 reset running", running_o, 0);
        check("R6 reset warn", warn_o, 0);
    endtask

    task automatic t_test_strobe;
        test_i = 1'b1;
        #1;
        check("R5 skip when flag set", skip_o, 1);
        @(negedge clk);
        test_i = 1'b0;
        check("R5 flag kept after test", flag_o, 1);
        wait_n(600);
        check("R4 flag sticky", flag_o, 1);
        check("R4 no reload", running_o, 0);
    endtask

    task automatic t_restart;
        start_cmd(8'h85);
        wait_n(100);
        test_i = 1'b1;
        #1;
        check("R5 no skip while counting", skip_o, 0);
        @(negedge clk);
        test_i = 1'b0;
        run_interval("R8 restart", 8'h81, 0);
    endtask

    task automatic t_collide;
        start_cmd(8'h80);
        wait_n(UNIT_CLK - 1);
        start_cmd(8'h80);
        check("R10 start wins flag", flag_o, 0);
        check("R10 start wins running", running_o, 1);
        wait_n(UNIT_CLK - 1);
        check("R10 new interval pending", flag_o, 0);
        wait_n(1);
        check("R10 new interval ends", flag_o, 1);
    endtask

    task automatic t_reset_mid;
        start_cmd(8'h83);
        wait_n(50);
        rst_i = 1'b1;
        wait_n(2);
        rst_i = 1'b0;
        check("R6 reset stops running", running_o, 0);
        check("R6 reset clears flag", flag_o, 0);
        wait_n(2000);
        check("R6 no expiry after reset", flag_o, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_i = 1'b0;
        wait_n(1);
        t_reset();
        run_interval("R2 min", 8'h80, 0);
        t_test_strobe();
        run_interval("R2 mid", 8'h8A, 0);
        run_interval("R3 tag ignored", 8'h45, 1);
        run_interval("R7 tag 11", 8'hC0, 1);
        run_interval("R2 max", 8'hBF, 0);
        t_restart();
        t_collide();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule